// File: doc/BRIEF.md
# Pushbutton Up/Down Position Controller

This block turns two active-low pushbutton inputs into a 5-bit position code in the range 0 to 31. That code drives a 32-tap selector. Each raw input passes through a two-flop synchroniser and then a bounce filter. The filter times every level change and accepts a new level only after it has stayed unchanged for a set time.

A settled press moves the code by one step. A press that stays held long enough switches to a steady auto-repeat. When both buttons are held, nothing moves. The code stops at either end of its range.

All timing is counted in ticks of a clock-enable input, so the time base is set outside the block. A pin chosen at reset decides whether the code starts at mid-scale or at zero. Each change of the code is announced by a one-cycle strobe and a direction bit.

Top module: `updown_pos_ctrl`

## Requirements
- R1: While rst_n is low, each clock edge loads the code with 16 if preset_zero is low, or with 0 if preset_zero is high. step is 0 during reset.
- R2: A level change on up_n or dn_n that lasts fewer than DB_TICKS ticks is ignored. A pressed or released level is accepted only after it has held for DB_TICKS ticks, so a bouncing press counts as a single press.
- R3: Each accepted press moves the code by exactly one step. A press of up_n (input low) adds 1 and sets step_up to 1. A press of dn_n subtracts 1 and sets step_up to 0.
- R4: The hold timer starts at the accepted press. If the press is still held HOLD_TICKS ticks after that first step, one more step follows. After that, a step follows every REP_TICKS ticks until the button is released.
- R5: The code saturates at 0 and at 31. A step toward an end that has already been reached changes nothing and raises no strobe.
- R6: While both buttons are accepted as pressed, the code does not change. When one of them is released, the button still held takes effect. It gives one step and starts its hold timing afresh.
- R7: The debounce, hold and repeat counters advance only in cycles where tick is high. With tick low, no press is ever accepted.
- R8: step is high for exactly one cycle each time the code changes, in the same cycle as the new code. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Clock enable that sets the time base for all counters |
| preset_zero | input | 1 | Reset preset select: 0 selects mid-scale (16), 1 selects zero |
| up_n | input | 1 | Up pushbutton, active low |
| dn_n | input | 1 | Down pushbutton, active low |
| pos | output | 5 | Position code, 0 to 31 |
| step | output | 1 | One-cycle strobe when the code changes |
| step_up | output | 1 | Direction of the last step: 1 means up, 0 means down |

## Verification
The situations hardest to reach from the ports are the handover from both-pressed to a single button and saturation in the middle of fast scan. Both depend on long filtered time windows lining up with each other.

The bench builds the block with short tick counts so that a held press crosses the hold threshold and several repeat periods within a few hundred cycles. It chooses hold lengths that sit midway between step instants, so the expected step count does not depend on a cycle of latency. Starting from the zero preset, a long hold of the up button runs into code 31. A second button is pressed and released partway through another press to force the handover.

// File: rtl/updown_pos_ctrl.sv
module updown_pos_ctrl #(
  parameter int DB_TICKS   = 10,
  parameter int HOLD_TICKS = 1000,
  parameter int REP_TICKS  = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       preset_zero,
  input  logic       up_n,
  input  logic       dn_n,
  output logic [4:0] pos,
  output logic       step,
  output logic       step_up
);
  localparam int DBW = $clog2(DB_TICKS + 1);
  localparam int HW  = $clog2(HOLD_TICKS + REP_TICKS + 1);
  localparam logic [4:0] MID = 5'd16;
  localparam logic [4:0] TOP = 5'd31;

  // bit 1 = up, bit 0 = down, active high after inversion
  logic [1:0] s1, s2, db, act, act_q;
  logic [DBW-1:0] dcnt [2];
  logic [HW-1:0] hcnt;
  logic scan, fire, can;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 2'b00;
      s2 <= 2'b00;
    end else begin
      s1 <= {~up_n, ~dn_n};
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        db[i]   <= 1'b0;
        dcnt[i] <= '0;
      end else if (s2[i] == db[i]) begin
        dcnt[i] <= '0;
      end else if (tick) begin
        if (dcnt[i] == DBW'(DB_TICKS - 1)) begin
          db[i]   <= s2[i];
          dcnt[i] <= '0;
        end else begin
          dcnt[i] <= dcnt[i] + 1'b1;
        end
      end
    end
  end

  assign act = (db == 2'b10 || db == 2'b01) ? db : 2'b00;

  logic [HW-1:0] lim;
  assign lim  = scan ? HW'(REP_TICKS - 1) : HW'(HOLD_TICKS - 1);
  assign fire = (act != 2'b00) && ((act != act_q) || (tick && hcnt == lim));
  assign can  = act[1] ? (pos != TOP) : (pos != 5'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 2'b00;
      hcnt  <= '0;
      scan  <= 1'b0;
    end else begin
      act_q <= act;
      if (act != act_q) begin
        hcnt <= '0;
        scan <= 1'b0;
      end else if (act != 2'b00 && tick) begin
        if (hcnt == lim) begin
          hcnt <= '0;
          scan <= 1'b1;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos     <= preset_zero ? 5'd0 : MID;
      step    <= 1'b0;
      step_up <= 1'b0;
    end else begin
      step <= fire && can;
      if (fire && can) begin
        pos     <= act[1] ? pos + 1'b1 : pos - 1'b1;
        step_up <= act[1];
      end
    end
  end
endmodule

// File: rtl/updown_pos_ctrl_chk.sv
module updown_pos_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] pos,
  input logic       step,
  input logic       step_up,
  input logic [1:0] db
);
  assert_step_up_adds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && step_up) |-> pos == $past(pos) + 5'd1);

  assert_step_dn_subs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !step_up) |-> pos == $past(pos) - 5'd1);

  assert_change_has_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pos != $past(pos)) |-> step);

  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> $past(pos) != (step_up ? 5'd31 : 5'd0));

  assert_both_held_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (db == 2'b11) |=> !step);
endmodule

bind updown_pos_ctrl updown_pos_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pos(pos), .step(step), .step_up(step_up), .db(db)
);

// File: tb/tb_updown_pos_ctrl.sv
module tb_updown_pos_ctrl;
  localparam int DB = 4, HOLD = 40, REP = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, preset_zero = 1'b0;
  logic up_n = 1'b1, dn_n = 1'b1;
  logic [4:0] pos;
  logic step, step_up;

  int checks = 0, errors = 0, mpos = 16;
  logic [5:0] exp_q[$];
  logic [5:0] e;
  bit done = 0;

  updown_pos_ctrl #(.DB_TICKS(DB), .HOLD_TICKS(HOLD), .REP_TICKS(REP)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .preset_zero(preset_zero),
    .up_n(up_n), .dn_n(dn_n), .pos(pos), .step(step), .step_up(step_up));

  always #10 clk = ~clk;

  // monitor: every strobe must match the next expected step (R3 R4 R8)
  always @(negedge clk) begin
    if (rst_n && step) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected step: dir=%0d pos=%0d expected none", step_up, pos);
      end else begin
        e = exp_q.pop_front();
        if ({step_up, pos} !== e) begin
          errors++;
          $display("FAIL R3 step mismatch: dir=%0d pos=%0d expected dir=%0d pos=%0d",
                   step_up, pos, e[5], e[4:0]);
        end
      end
    end
  end

  task automatic expect_step(bit up);
    if (up && mpos < 31) begin mpos++; exp_q.push_back({1'b1, 5'(mpos)}); end
    else if (!up && mpos > 0) begin mpos--; exp_q.push_back({1'b0, 5'(mpos)}); end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle(string req);
    wait_cyc(DB + 20);
    checks++;
    if (exp_q.size() != 0 || pos !== 5'(mpos)) begin
      errors++;
      $display("FAIL %s pending=%0d pos=%0d expected pending=0 pos=%0d", req, exp_q.size(), pos, mpos);
    end
    exp_q.delete();
  endtask

  task automatic press(bit up, int len, string req);
    int n;
    n = (len < DB) ? 0 : (len < HOLD) ? 1 : 2 + (len - HOLD) / REP;
    for (int k = 0; k < n; k++) expect_step(up);
    if (up) up_n = 1'b0; else dn_n = 1'b0;
    wait_cyc(len);
    up_n = 1'b1; dn_n = 1'b1;
    settle(req);
  endtask

  task automatic do_reset(bit pz);
    rst_n = 1'b0; preset_zero = pz;
    wait_cyc(3);
    rst_n = 1'b1;
    mpos = pz ? 0 : 16;
    wait_cyc(1);
    checks++;
    if (pos !== 5'(mpos) || step !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: pos=%0d step=%0d expected pos=%0d step=0", pos, step, mpos);
    end
  endtask

  initial begin
    do_reset(1'b0);                          // R1 mid-scale
    press(1'b1, 8, "R3 single up");
    press(1'b0, 8, "R3 single down");
    press(1'b1, 3, "R2 short press ignored");
    // R2 bouncing press and release count once
    expect_step(1'b1);
    up_n = 0; wait_cyc(1); up_n = 1; wait_cyc(1); up_n = 0; wait_cyc(2);
    up_n = 1; wait_cyc(1); up_n = 0; wait_cyc(30);
    up_n = 1; wait_cyc(2); up_n = 0; wait_cyc(1); up_n = 1;
    settle("R2 bounce");
    press(1'b1, 75, "R4 hold up");
    press(1'b0, 75, "R4 hold down");
    // R6 both pressed, then up released, down takes over
    expect_step(1'b1); expect_step(1'b0);
    up_n = 0; wait_cyc(30); dn_n = 0; wait_cyc(30);
    up_n = 1; wait_cyc(15); dn_n = 1;
    settle("R6 both then handover");
    // R6 both held long: nothing moves
    up_n = 0; dn_n = 0; wait_cyc(120); up_n = 1; dn_n = 1;
    settle("R6 both held long");
    // R7 tick low: no press accepted
    tick = 0; up_n = 0; wait_cyc(80); up_n = 1; wait_cyc(10); tick = 1;
    settle("R7 tick gated");
    do_reset(1'b1);                          // R1 zero-scale
    press(1'b0, 8, "R5 floor blocked");
    press(1'b1, 400, "R5 fast scan to top");
    press(1'b1, 8, "R5 top blocked");
    press(1'b0, 75, "R4 hold down from top");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule